// File: doc/BRIEF.md
# AUX Native Transaction Engine

This block carries out one native register access at a time over a DisplayPort-style AUX channel. A host hands it a 16-bit register address, a direction, a byte count of 1 to 16, a delay value and, for writes, a payload. From these the engine builds a four-byte request header. It streams the header, followed by the payload on writes, to a lower-level channel port. It then waits for that port to report the outcome of the attempt.

The channel port returns a two-bit channel status and a reply byte, and it may stream reply data bytes while the attempt is open. A busy channel is retried at once. A deferring sink is retried only after a fixed wait. A channel timeout or channel error ends the access. An acknowledged read has its data cut to the requested count and streamed out, and a single-cycle done strobe then reports the final status. The total number of attempts per access is bounded.

Top module: `aux_native_engine`

## Requirements
- R1: A request is sent as a byte stream with `tx_last` on its final byte, in this order: address bits [7:0]; address bits [15:8]; the command byte (0x80 for a write, 0x90 for a read); then a length byte whose upper nibble is the low four bits of the total message length and whose lower nibble is the count minus one. The total message length is count+4 for a write and 4 for a read. A write then appends payload bytes 0 to count-1, where byte i is `cmd_wdata[8i+7:8i]`.
- R2: A command with a count of 0 or more than 16 sends no byte. The cycle after acceptance it raises `done` with status 5 (length error).
- R3: After an acknowledged read, the bytes the channel returned during the final attempt are streamed on `rd_data`/`rd_valid` in arrival order, one per cycle. The stream is cut to the requested count (at most 16 bytes are held). It is followed by `done` with status 0.
- R4: Channel status 2 (busy) makes the engine resend the whole request starting in the next cycle, with no wait.
- R5: Channel status 0 with reply code 2'b10 (defer) in `ch_reply[5:4]` makes the engine stay silent for DEFER_US*CYC_PER_US cycles before it resends the request.
- R6: An access makes at most ATTEMPTS (default 7) attempts. If the last allowed attempt ends busy or deferred, the engine raises `done` with status 4 (I/O error) and sends nothing more.
- R7: Channel status 1 (timeout) or 3 (channel error) ends the access at once, with `done` status 1 or 3 respectively and no retry.
- R8: Channel status 0 with reply code 2'b00 in `ch_reply[5:4]` is success, whatever `ch_reply[7:6]` holds. Any code other than 2'b00 or 2'b10 ends the access with status 4.
- R9: From acceptance on, `ch_delay` holds `cmd_delay` divided by 10 (rounded down), and it is unchanged until the next acceptance.
- R10: `cmd_ready` is high after reset and is low from acceptance through the cycle in which `done` is high. `done` lasts exactly one cycle, and `cmd_ready` is high again in the next cycle.
- R11: An acknowledged write ends with `done` status 0 and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_write | input | 1 | 1 = native write, 0 = native read |
| cmd_addr | input | 16 | Register address |
| cmd_count | input | 5 | Data byte count, valid range 1..16 |
| cmd_delay | input | 8 | Requested channel delay |
| cmd_wdata | input | 128 | Write payload, byte i at bits [8i+7:8i] |
| tx_valid | output | 1 | Request byte available |
| tx_ready | input | 1 | Channel takes the request byte |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of the request |
| ch_delay | output | 8 | Delay for the channel, command delay / 10 |
| ch_rx_valid | input | 1 | Reply data byte from the channel |
| ch_rx_data | input | 8 | Reply data byte |
| ch_done | input | 1 | Attempt finished, status and reply valid |
| ch_status | input | 2 | 0 ok, 1 timeout, 2 busy, 3 channel error |
| ch_reply | input | 8 | Reply byte, code in bits [5:4] |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | Access finished (one cycle) |
| done_status | output | 3 | 0 ok, 1 timeout, 3 channel error, 4 I/O error, 5 length error |

## Verification
Two events can land in the same cycle here: the channel may hand over its last reply data byte in the very cycle it raises the completion strobe. The byte must then be captured and counted in the length of the read stream, even though the wait for the reply ends on that edge. The bench provokes this by driving the final data byte together with `ch_done`, and it judges the result by checking that the byte shows up last in the read stream, with the full expected count. Overlong replies are also cut at the requested count in the same evaluation.

// File: rtl/aux_native_engine.sv
module aux_native_engine #(
  parameter int ATTEMPTS   = 7,
  parameter int DEFER_US   = 400,
  parameter int CYC_PER_US = 125
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_write,
  input  logic [15:0]  cmd_addr,
  input  logic [4:0]   cmd_count,
  input  logic [7:0]   cmd_delay,
  input  logic [127:0] cmd_wdata,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [7:0]   tx_data,
  output logic         tx_last,
  output logic [7:0]   ch_delay,
  input  logic         ch_rx_valid,
  input  logic [7:0]   ch_rx_data,
  input  logic         ch_done,
  input  logic [1:0]   ch_status,
  input  logic [7:0]   ch_reply,
  output logic         rd_valid,
  output logic [7:0]   rd_data,
  output logic         done,
  output logic [2:0]   done_status
);
  localparam int MAXB      = 16;
  localparam int DEFER_CYC = DEFER_US * CYC_PER_US;
  localparam int DCW       = $clog2(DEFER_CYC + 1);
  localparam int AW        = $clog2(ATTEMPTS + 1);

  localparam logic [2:0] ST_OK = 3'd0, ST_TMO = 3'd1, ST_CHE = 3'd3,
                         ST_IOE = 3'd4, ST_LEN = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_DEFER, S_DRAIN, S_DONE} state_t;
  state_t st;

  logic          wr_q;
  logic [15:0]   addr_q;
  logic [4:0]    cnt_q;
  logic [127:0]  wbuf_q;
  logic [7:0]    rbuf [MAXB];
  logic [4:0]    idx;
  logic [4:0]    rx_cnt;
  logic [4:0]    dlen;
  logic [AW-1:0] att;
  logic [DCW-1:0] dcnt;
  logic [2:0]    stat_q;
  logic [7:0]    dly_q;

  wire        count_bad = (cmd_count == 5'd0) || (cmd_count > 5'(MAXB));
  wire [4:0]  last_idx  = wr_q ? cnt_q + 5'd3 : 5'd3;
  wire [4:0]  total     = wr_q ? cnt_q + 5'd4 : 5'd4;
  wire [4:0]  cnt_m1    = cnt_q - 5'd1;
  wire        rx_take   = (st == S_WAIT) && ch_rx_valid && (rx_cnt < 5'(MAXB));
  wire [4:0]  rx_cnt_nx = rx_cnt + {4'd0, rx_take};
  wire [4:0]  keep_len  = (rx_cnt_nx < cnt_q) ? rx_cnt_nx : cnt_q;
  wire [1:0]  code      = ch_reply[5:4];
  wire        can_retry = (att != AW'(ATTEMPTS - 1));

  assign cmd_ready   = (st == S_IDLE);
  assign tx_valid    = (st == S_SEND);
  assign tx_last     = tx_valid && (idx == last_idx);
  assign rd_valid    = (st == S_DRAIN);
  assign rd_data     = rbuf[idx[3:0]];
  assign done        = (st == S_DONE);
  assign done_status = stat_q;
  assign ch_delay    = dly_q;

  always_comb begin
    case (idx)
      5'd0:    tx_data = addr_q[7:0];
      5'd1:    tx_data = addr_q[15:8];
      5'd2:    tx_data = wr_q ? 8'h80 : 8'h90;
      5'd3:    tx_data = {total[3:0], cnt_m1[3:0]};
      default: tx_data = wbuf_q[(int'(idx) - 4) * 8 +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rx_take) rbuf[rx_cnt[3:0]] <= ch_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wr_q <= 1'b0;
      addr_q <= '0;
      cnt_q <= '0;
      wbuf_q <= '0;
      idx <= '0;
      rx_cnt <= '0;
      dlen <= '0;
      att <= '0;
      dcnt <= '0;
      stat_q <= ST_OK;
      dly_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          wr_q   <= cmd_write;
          addr_q <= cmd_addr;
          cnt_q  <= cmd_count;
          wbuf_q <= cmd_wdata;
          dly_q  <= cmd_delay / 8'd10;
          att    <= '0;
          idx    <= '0;
          rx_cnt <= '0;
          if (count_bad) begin
            stat_q <= ST_LEN;
            st     <= S_DONE;
          end else begin
            st <= S_SEND;
          end
        end
        S_SEND: if (tx_ready) begin
          if (idx == last_idx) begin
            idx <= '0;
            st  <= S_WAIT;
          end else begin
            idx <= idx + 5'd1;
          end
        end
        S_WAIT: begin
          rx_cnt <= rx_cnt_nx;
          if (ch_done) begin
            case (ch_status)
              2'd1: begin stat_q <= ST_TMO; st <= S_DONE; end
              2'd3: begin stat_q <= ST_CHE; st <= S_DONE; end
              2'd2: begin
                if (can_retry) begin
                  att <= att + AW'(1);
                  rx_cnt <= '0;
                  idx <= '0;
                  st <= S_SEND;
                end else begin
                  stat_q <= ST_IOE;
                  st <= S_DONE;
                end
              end
              default: begin
                if (code == 2'b00) begin
                  stat_q <= ST_OK;
                  dlen <= keep_len;
                  idx <= '0;
                  st <= (!wr_q && keep_len != 5'd0) ? S_DRAIN : S_DONE;
                end else if (code == 2'b10 && can_retry) begin
                  att <= att + AW'(1);
                  dcnt <= DCW'(DEFER_CYC - 1);
                  st <= S_DEFER;
                end else begin
                  stat_q <= ST_IOE;
                  st <= S_DONE;
                end
              end
            endcase
          end
        end
        S_DEFER: begin
          if (dcnt == '0) begin
            rx_cnt <= '0;
            idx <= '0;
            st <= S_SEND;
          end else begin
            dcnt <= dcnt - DCW'(1);
          end
        end
        S_DRAIN: begin
          if (idx == dlen - 5'd1) st <= S_DONE;
          else idx <= idx + 5'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_len_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_count == 5'd0 || cmd_count > 5'd16)
      |=> done && done_status == 3'd5 && !tx_valid);

  p_busy_resend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT && ch_done && ch_status == 2'd2
      |=> tx_valid || (done && done_status == 3'd4));

  p_defer_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT && ch_done && ch_status == 2'd0 && ch_reply[5:4] == 2'b10
      |=> !tx_valid);

  p_attempt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    att < AW'(ATTEMPTS));

  p_fatal_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT && ch_done && (ch_status == 2'd1 || ch_status == 2'd3)
      |=> done && done_status == {1'b0, $past(ch_status)});

  p_read_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> idx < cnt_q && !wr_q);

  p_delay_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> $stable(ch_delay));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);
endmodule

// File: tb/test_aux_native_engine.sv
module test_aux_native_engine;
  localparam int DEFER_CYC = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0;
  logic [15:0] cmd_addr = '0;
  logic [4:0] cmd_count = '0;
  logic [7:0] cmd_delay = '0;
  logic [127:0] cmd_wdata = '0;
  logic tx_ready = 1'b1;
  logic ch_rx_valid = 0, ch_done = 0;
  logic [7:0] ch_rx_data = '0, ch_reply = '0;
  logic [1:0] ch_status = '0;
  logic cmd_ready, tx_valid, tx_last, rd_valid, done;
  logic [7:0] tx_data, ch_delay, rd_data;
  logic [2:0] done_status;

  aux_native_engine #(.ATTEMPTS(7), .DEFER_US(400), .CYC_PER_US(1)) i_aux_native_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .cmd_delay(cmd_delay), .cmd_wdata(cmd_wdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .ch_delay(ch_delay),
    .ch_rx_valid(ch_rx_valid), .ch_rx_data(ch_rx_data), .ch_done(ch_done),
    .ch_status(ch_status), .ch_reply(ch_reply), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .done_status(done_status));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R10";
  logic [7:0] exp_tx[$], exp_rd[$];
  logic [2:0] exp_st[$];
  logic [1:0] q_st[$];
  logic [7:0] q_rep[$];
  int q_nrx[$], q_gap[$];
  bit q_join[$];

  task automatic chk(bit ok, string t, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", t, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(logic [15:0] a, int i);
    return 8'(int'(a[7:0]) + i * 29 + 1);
  endfunction

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) chk(0, tag, "unexpected request byte", tx_data, 0);
      else begin logic [7:0] e; e = exp_tx.pop_front(); chk(tx_data == e, tag, "request byte", tx_data, e); end
    end
    if (rd_valid) begin
      if (exp_rd.size() == 0) chk(0, tag, "unexpected read byte", rd_data, 0);
      else begin logic [7:0] e; e = exp_rd.pop_front(); chk(rd_data == e, tag, "read byte", rd_data, e); end
    end
    if (done) begin
      if (exp_st.size() == 0) chk(0, tag, "unexpected done", done_status, 0);
      else begin logic [2:0] e; e = exp_st.pop_front(); chk(done_status == e, tag, "final status", done_status, e); end
    end
  end

  // channel model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_valid && tx_last && q_st.size() > 0) begin
        logic [1:0] s; logic [7:0] rp; int n, gap; bit jn;
        s = q_st.pop_front(); rp = q_rep.pop_front(); n = q_nrx.pop_front();
        jn = q_join.pop_front(); gap = q_gap.pop_front();
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
          ch_rx_valid = 1'b1; ch_rx_data = 8'hC0 + 8'(i);
          if (jn && i == n - 1) begin ch_done = 1'b1; ch_status = s; ch_reply = rp; end
          @(negedge clk);
        end
        ch_rx_valid = 1'b0;
        if (!(jn && n > 0)) begin
          ch_done = 1'b1; ch_status = s; ch_reply = rp;
          @(negedge clk);
        end
        ch_done = 1'b0;
        if (gap > 0) begin
          int g; g = 1;
          while (!tx_valid && g < 2000) begin @(negedge clk); g++; end
          chk(g == gap, (s == 2'd2) ? "R4" : "R5", "cycles to resend", g, gap);
        end
      end
    end
  end

  task automatic resp(logic [1:0] s, logic [7:0] rp, int n, bit jn, int gap);
    q_st.push_back(s); q_rep.push_back(rp); q_nrx.push_back(n);
    q_join.push_back(jn); q_gap.push_back(gap);
  endtask

  task automatic xact(bit wr, logic [15:0] a, int n, logic [7:0] dly,
                      int attempts, logic [2:0] est, int nrd, string t);
    logic [127:0] wd;
    tag = t;
    wd = '0;
    for (int i = 0; i < 16; i++) wd[8*i +: 8] = pbyte(a, i);
    for (int k = 0; k < attempts; k++) begin
      exp_tx.push_back(a[7:0]);
      exp_tx.push_back(a[15:8]);
      exp_tx.push_back(wr ? 8'h80 : 8'h90);
      exp_tx.push_back({4'(wr ? n + 4 : 4), 4'(n - 1)});
      if (wr) for (int i = 0; i < n; i++) exp_tx.push_back(pbyte(a, i));
    end
    for (int i = 0; i < nrd; i++) exp_rd.push_back(8'hC0 + 8'(i));
    exp_st.push_back(est);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_count = 5'(n);
    cmd_delay = dly; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(cmd_ready == 1'b0, "R10", "ready during done", cmd_ready, 0);
    chk(ch_delay == dly / 8'd10, "R9", "channel delay", ch_delay, dly / 8'd10);
    @(negedge clk);
    chk(cmd_ready == 1'b1 && done == 1'b0, "R10", "ready after done", {cmd_ready, done}, 2'b10);
    chk(exp_tx.size() == 0, (attempts == 7) ? "R6" : t, "request bytes missing", exp_tx.size(), 0);
    chk(exp_rd.size() == 0, t, "read bytes missing", exp_rd.size(), 0);
    exp_tx.delete(); exp_rd.delete(); q_st.delete();
    q_rep.delete(); q_nrx.delete(); q_join.delete(); q_gap.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !tx_valid && !done && !rd_valid, "R10", "reset state",
        {cmd_ready, tx_valid, done, rd_valid}, 4'b1000);

    // R1 R11: single byte write, 16 byte write (length nibble wraps)
    resp(2'd0, 8'h00, 0, 0, 0);
    xact(1, 16'h0102, 1, 8'd0, 1, 3'd0, 0, "R11");
    resp(2'd0, 8'h00, 0, 0, 0);
    xact(1, 16'hABCD, 16, 8'd100, 1, 3'd0, 0, "R1");

    // R3 reads: exact, overlong, full, short, byte joined with completion
    resp(2'd0, 8'h00, 4, 0, 0);
    xact(0, 16'h0200, 4, 8'd9, 1, 3'd0, 4, "R3");
    resp(2'd0, 8'h00, 20, 0, 0);
    xact(0, 16'h0300, 3, 8'd0, 1, 3'd0, 3, "R3");
    resp(2'd0, 8'h00, 18, 0, 0);
    xact(0, 16'h0400, 16, 8'd0, 1, 3'd0, 16, "R3");
    resp(2'd0, 8'h00, 2, 0, 0);
    xact(0, 16'h0500, 5, 8'd0, 1, 3'd0, 2, "R3");
    resp(2'd0, 8'h00, 2, 1, 0);
    xact(0, 16'h0600, 2, 8'd0, 1, 3'd0, 2, "R3");

    // R4 busy twice then ack
    resp(2'd2, 8'h00, 0, 0, 1);
    resp(2'd2, 8'h00, 0, 0, 1);
    resp(2'd0, 8'h00, 0, 0, 0);
    xact(1, 16'h0700, 2, 8'd0, 3, 3'd0, 0, "R4");

    // R5 defer then ack read
    resp(2'd0, 8'h20, 0, 0, DEFER_CYC + 1);
    resp(2'd0, 8'h00, 1, 0, 0);
    xact(0, 16'h0800, 1, 8'd0, 2, 3'd0, 1, "R5");

    // R6 budget exhausted by busy, and by defer
    for (int k = 0; k < 6; k++) resp(2'd2, 8'h00, 0, 0, 1);
    resp(2'd2, 8'h00, 0, 0, 0);
    xact(1, 16'h0900, 1, 8'd0, 7, 3'd4, 0, "R6");
    for (int k = 0; k < 6; k++) resp(2'd0, 8'h20, 0, 0, DEFER_CYC + 1);
    resp(2'd0, 8'h20, 0, 0, 0);
    xact(0, 16'h0A00, 1, 8'd0, 7, 3'd4, 0, "R6");

    // R7 timeout and channel error
    resp(2'd1, 8'h00, 0, 0, 0);
    xact(1, 16'h0B00, 1, 8'd0, 1, 3'd1, 0, "R7");
    resp(2'd3, 8'h00, 0, 0, 0);
    xact(0, 16'h0C00, 1, 8'd0, 1, 3'd3, 0, "R7");

    // R8 nack, reserved code, ack with upper bits set
    resp(2'd0, 8'h10, 0, 0, 0);
    xact(1, 16'h0D00, 1, 8'd0, 1, 3'd4, 0, "R8");
    resp(2'd0, 8'h30, 0, 0, 0);
    xact(0, 16'h0E00, 1, 8'd0, 1, 3'd4, 0, "R8");
    resp(2'd0, 8'hC0, 1, 0, 0);
    xact(0, 16'h0F00, 1, 8'd0, 1, 3'd0, 1, "R8");

    // R2 bad counts, R9 large delay
    xact(1, 16'h1000, 17, 8'd255, 0, 3'd5, 0, "R2");
    xact(0, 16'h1100, 0, 8'd47, 0, 3'd5, 0, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule